// File: doc/BRIEF.md
# Six-Channel Simultaneous ADC Readout Sequencer

This block drives an external six-channel, 16-bit converter whose channels all sample at one instant. It produces the converter's clock by dividing the system clock (5 MHz from 100 MHz by default). After reset it holds the converter's reset line active for a fixed number of cycles. From then on it waits for a mains-synchronous sample pulse from outside and passes it to the converter as a hold/convert strobe. No internal timer starts conversions.

The converter reports its results as three channel pairs. Each pair raises an end-of-conversion strobe when it is ready. On each such strobe the sequencer reads the two channels of that pair. For each read it places the channel number on the address lines, drives chip-select and read-strobe low for a set number of system clocks, and captures the 16-bit data bus on the last of those clocks. The converter is set up so that each read returns one full 16-bit word with no address bits embedded. Each word leaves on a valid/ready stream with a 3-bit channel index, and the flag marking the end of a frame is set on channel 5.

The controller is a single state machine with these states:
- `ST_RESET`: startup reset of the converter.
- `ST_IDLE`: waiting for a trigger.
- `ST_HOLD`: hold strobe to the converter.
- `ST_WAIT_EOC`: waiting for a pair to finish.
- `ST_READ`: strobed read of one channel.
- `ST_PUSH`: offering the word on the stream.

The transitions are:
- reset done: `ST_RESET` to `ST_IDLE`.
- trigger: `ST_IDLE` to `ST_HOLD`.
- hold done: `ST_HOLD` to `ST_WAIT_EOC`.
- pair ready: `ST_WAIT_EOC` to `ST_READ`.
- timeout: `ST_WAIT_EOC` to `ST_IDLE`.
- read done: `ST_READ` to `ST_PUSH`.
- next channel: `ST_PUSH` to `ST_READ`, after an even channel.
- next pair: `ST_PUSH` to `ST_WAIT_EOC`, after channel 1 or 3.
- frame done: `ST_PUSH` to `ST_IDLE`, after channel 5.

A trigger that comes while a frame is in flight is dropped and raises an overrun pulse. If a pair's end-of-conversion strobe has not come within 64 converter clocks, the block raises a timeout pulse and goes back to idle.

Top module: `adc6_frame_seq`

## Requirements
- R1: `cnv_clk_o` is a square wave with a period of 2*CLK_HALF system clocks, high for CLK_HALF of them (20 and 10 by default).
- R2: After reset is released, `cnv_rst_n_o` stays low for RST_CYCLES system clocks. A trigger seen during that time is ignored: no hold strobe, no overrun pulse and no output word.
- R3: A rising edge on `sync_trig_i` while idle produces exactly one `cnv_hold_o` pulse, HOLD_CYCLES system clocks wide. While the hold strobe is high, chip-select stays inactive.
- R4: Each end-of-conversion rising edge starts the reads of the next pair, channel 2p and then channel 2p+1. The six reads of a frame use addresses 0,1,2,3,4,5 in that order. During each read, `cnv_cs_n_o` and `cnv_rd_n_o` are low together for READ_CYCLES system clocks and the address does not change.
- R5: The word captured on the last read clock is delivered on `m_data_o`. Its `m_chan_o` equals the address it was read from, giving channels 0 to 5 in order, and `m_last_o` is high only for channel 5.
- R6: While `m_valid_o` is high and `m_ready_i` is low, the word and its channel index stay unchanged. No word is lost or repeated.
- R7: A trigger rising edge during a frame raises `overrun_o` for one cycle, starts no new hold, and leaves the current frame's six words unchanged.
- R8: If no end-of-conversion edge arrives within 64 converter clocks in `ST_WAIT_EOC`, `timeout_o` pulses for one cycle, the block returns to idle with no further reads, and the next trigger starts a fresh frame at channel 0.
- R9: An end-of-conversion edge that arrives while the previous word is still held by back-pressure is remembered. The next pair is then read without waiting for another edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_trig_i | input | 1 | External mains-synchronous sample pulse (asynchronous) |
| cnv_clk_o | output | 1 | Converter clock |
| cnv_rst_n_o | output | 1 | Converter reset, active low |
| cnv_hold_o | output | 1 | Hold/convert strobe to the converter |
| cnv_eoc_i | input | 1 | End-of-conversion strobe, active high (asynchronous) |
| cnv_cs_n_o | output | 1 | Converter chip-select, active low |
| cnv_rd_n_o | output | 1 | Converter read strobe, active low |
| cnv_addr_o | output | 3 | Channel address of the current read |
| cnv_data_i | input | 16 | Converter parallel data bus |
| m_valid_o | output | 1 | Output word valid |
| m_ready_i | input | 1 | Output word accepted |
| m_data_o | output | 16 | Sample word |
| m_chan_o | output | 3 | Channel index of the word (0 to 5) |
| m_last_o | output | 1 | Last word of the frame (channel 5) |
| overrun_o | output | 1 | One-cycle pulse: trigger dropped while busy |
| timeout_o | output | 1 | One-cycle pulse: end-of-conversion wait expired |

## Verification
The bench sweeps four back-pressure patterns against several converter response delays. One of these combinations makes an end-of-conversion edge arrive while a word is still waiting to be taken. A design without a pending flag would then hang in `ST_WAIT_EOC` and end in a timeout with only two or four words delivered. Overrun is checked by re-triggering in the middle of a frame: a design that accepts the trigger would issue a second hold and repeat or corrupt words, and one that flags nothing leaves the overrun count at zero. Timeouts are forced on the first pair and on the second pair, and the timeout delay is measured against 64 converter periods. After each timeout the bench checks that the next frame starts again at channel 0; a design that kept its channel counter would skip channels there.

// File: rtl/adc6_seq_pkg.sv
package adc6_seq_pkg;

    localparam int unsigned CHAN_W       = 3;
    localparam int unsigned NUM_CHANNELS = 6;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_IDLE,
        ST_HOLD,
        ST_WAIT_EOC,
        ST_READ,
        ST_PUSH
    } seq_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc6_clkgen.sv
module adc6_clkgen #(
    parameter int unsigned HALF_PERIOD = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic cclk_o,
    output logic rise_tick_o
);
    localparam int unsigned DIV_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

    logic [DIV_W-1:0] div_q;
    logic             at_end;

    assign at_end = (div_q == DIV_W'(HALF_PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q       <= '0;
            cclk_o      <= 1'b0;
            rise_tick_o <= 1'b0;
        end else begin
            rise_tick_o <= at_end && !cclk_o;
            if (at_end) begin
                div_q  <= '0;
                cclk_o <= ~cclk_o;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    // R1
    tick_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick_o |-> (cclk_o && !$past(cclk_o)));

endmodule

// File: rtl/adc6_edge_sync.sv
module adc6_edge_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= async_i[b];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign rise_o[b] = sync_q && !prev_q;
    end

endmodule

// File: rtl/adc6_wait_timer.sv
module adc6_wait_timer #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int unsigned TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != TW'(LIMIT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == TW'(LIMIT));

    // R8
    timer_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> !expired_o);

endmodule

// File: rtl/adc6_frame_seq.sv
module adc6_frame_seq
    import adc6_seq_pkg::*;
#(
    parameter int unsigned CLK_HALF    = 10,
    parameter int unsigned RST_CYCLES  = 8,
    parameter int unsigned HOLD_CYCLES = 4,
    parameter int unsigned READ_CYCLES = 4,
    parameter int unsigned EOC_TIMEOUT = 64,
    parameter int unsigned DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_trig_i,
    output logic              cnv_clk_o,
    output logic              cnv_rst_n_o,
    output logic              cnv_hold_o,
    input  logic              cnv_eoc_i,
    output logic              cnv_cs_n_o,
    output logic              cnv_rd_n_o,
    output logic [CHAN_W-1:0] cnv_addr_o,
    input  logic [DATA_W-1:0] cnv_data_i,
    output logic              m_valid_o,
    input  logic              m_ready_i,
    output logic [DATA_W-1:0] m_data_o,
    output logic [CHAN_W-1:0] m_chan_o,
    output logic              m_last_o,
    output logic              overrun_o,
    output logic              timeout_o
);
    localparam int unsigned CNT_MAX   = max3(RST_CYCLES, HOLD_CYCLES, READ_CYCLES);
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0]  RST_LAST  = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W-1:0]  HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0]  READ_LAST = CNT_W'(READ_CYCLES - 1);
    localparam logic [CHAN_W-1:0] LAST_CHAN = CHAN_W'(NUM_CHANNELS - 1);

    // synchronised edges of the asynchronous inputs
    logic [1:0] rise_vec;
    logic       trig_rise, eoc_rise;
    logic       cclk_tick, tmo_expired;

    adc6_clkgen #(.HALF_PERIOD(CLK_HALF)) i_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cclk_o     (cnv_clk_o),
        .rise_tick_o(cclk_tick)
    );

    adc6_edge_sync #(.WIDTH(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cnv_eoc_i, sync_trig_i}),
        .rise_o (rise_vec)
    );

    assign trig_rise = rise_vec[0];
    assign eoc_rise  = rise_vec[1];

    // state and datapath registers
    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CHAN_W-1:0] chan_q, chan_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              eoc_pend_q, eoc_pend_d;
    logic              overrun_d, timeout_d;

    adc6_wait_timer #(.LIMIT(EOC_TIMEOUT)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state_q == ST_WAIT_EOC),
        .tick_i   (cclk_tick),
        .expired_o(tmo_expired)
    );

    // next-state and datapath logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        chan_d    = chan_q;
        data_d    = data_q;
        timeout_d = 1'b0;

        unique case (state_q)
            ST_RESET: begin
                if (cnt_q == RST_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_IDLE: begin
                if (trig_rise) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                    chan_d  = '0;
                end
            end
            ST_HOLD: begin
                if (cnt_q == HOLD_LAST) begin
                    state_d = ST_WAIT_EOC;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WAIT_EOC: begin
                if (eoc_pend_q || eoc_rise) begin
                    state_d = ST_READ;
                    cnt_d   = '0;
                end else if (tmo_expired) begin
                    state_d   = ST_IDLE;
                    timeout_d = 1'b1;
                end
            end
            ST_READ: begin
                if (cnt_q == READ_LAST) begin
                    state_d = ST_PUSH;
                    data_d  = cnv_data_i;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PUSH: begin
                if (m_ready_i) begin
                    cnt_d = '0;
                    if (chan_q == LAST_CHAN) begin
                        state_d = ST_IDLE;
                    end else begin
                        chan_d  = chan_q + 1'b1;
                        state_d = chan_q[0] ? ST_WAIT_EOC : ST_READ;
                    end
                end
            end
            default: state_d = ST_RESET;
        endcase
    end

    // pending end-of-conversion and overrun detection
    always_comb begin
        eoc_pend_d = eoc_pend_q;
        if (state_q == ST_IDLE || state_q == ST_RESET || state_q == ST_WAIT_EOC) begin
            eoc_pend_d = 1'b0;
        end else if (eoc_rise) begin
            eoc_pend_d = 1'b1;
        end
        overrun_d = trig_rise && (state_q != ST_IDLE) && (state_q != ST_RESET);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RESET;
            cnt_q      <= '0;
            chan_q     <= '0;
            data_q     <= '0;
            eoc_pend_q <= 1'b0;
            overrun_o  <= 1'b0;
            timeout_o  <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            chan_q     <= chan_d;
            data_q     <= data_d;
            eoc_pend_q <= eoc_pend_d;
            overrun_o  <= overrun_d;
            timeout_o  <= timeout_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        cnv_rst_n_o = (state_q != ST_RESET);
        cnv_hold_o  = (state_q == ST_HOLD);
        cnv_cs_n_o  = (state_q != ST_READ);
        cnv_rd_n_o  = (state_q != ST_READ);
        cnv_addr_o  = chan_q;
        m_valid_o   = (state_q == ST_PUSH);
        m_data_o    = data_q;
        m_chan_o    = chan_q;
        m_last_o    = (state_q == ST_PUSH) && (chan_q == LAST_CHAN);
    end

    // R2
    quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_rst_n_o |-> (!m_valid_o && !cnv_hold_o && cnv_cs_n_o));

    // R3
    hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_hold_o |-> (cnv_cs_n_o && cnv_rd_n_o && cnv_rst_n_o));

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_rd_n_o && !$past(cnv_rd_n_o)) |-> $stable(cnv_addr_o));

    // R5
    last_on_ch5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_last_o |-> (m_valid_o && m_chan_o == LAST_CHAN));

    // R6
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_chan_o)));

    // R7
    overrun_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> ($past(state_q) != ST_IDLE && $past(state_q) != ST_RESET));

    // R8
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (state_q == ST_IDLE && $past(state_q) == ST_WAIT_EOC));

endmodule

// File: tb/test_adc6_frame_seq.sv
module test_adc6_frame_seq;

    localparam int HALF  = 10;
    localparam int RSTC  = 8;
    localparam int HOLDC = 4;
    localparam int READC = 4;
    localparam int TMO   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_trig = 1'b0;
    logic        cnv_clk, cnv_rst_n, cnv_hold, cnv_cs_n, cnv_rd_n;
    logic        cnv_eoc = 1'b0;
    logic [2:0]  cnv_addr;
    logic [15:0] cnv_data;
    logic        m_valid, m_last, overrun, timeout;
    logic        m_ready = 1'b1;
    logic [15:0] m_data;
    logic [2:0]  m_chan;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    adc6_frame_seq i_adc6_frame_seq (
        .clk(clk), .rst_n(rst_n), .sync_trig_i(sync_trig),
        .cnv_clk_o(cnv_clk), .cnv_rst_n_o(cnv_rst_n), .cnv_hold_o(cnv_hold),
        .cnv_eoc_i(cnv_eoc), .cnv_cs_n_o(cnv_cs_n), .cnv_rd_n_o(cnv_rd_n),
        .cnv_addr_o(cnv_addr), .cnv_data_i(cnv_data),
        .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
        .m_chan_o(m_chan), .m_last_o(m_last),
        .overrun_o(overrun), .timeout_o(timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] smp(input int f, input int a);
        return 16'((f * 6 + a) * 2621 + 4951);
    endfunction

    // converter model
    int mdl_frame = 0;
    int eoc_dly   = 5;
    int skip_pair = -1;

    assign cnv_data = (!cnv_cs_n && !cnv_rd_n) ? smp(mdl_frame, int'(cnv_addr)) : 16'hDEAD;

    initial begin
        int   cd = -1;
        int   ew = 0;
        int   laddr = 0;
        logic hp = 1'b0;
        logic rp = 1'b1;
        forever begin
            @(negedge clk);
            if (cnv_hold && !hp) begin
                mdl_frame++;
                if (skip_pair != 0) cd = eoc_dly;
            end
            if (!cnv_rd_n) laddr = int'(cnv_addr);
            if (cnv_rd_n && !rp && (laddr % 2 == 1) && laddr != 5 &&
                skip_pair != (laddr + 1) / 2) cd = eoc_dly;
            hp = cnv_hold;
            rp = cnv_rd_n;
            if (ew > 0) begin
                ew--;
                if (ew == 0) cnv_eoc = 1'b0;
            end
            if (cd == 0) begin
                cnv_eoc = 1'b1;
                ew = 2;
                cd = -1;
            end else if (cd > 0) begin
                cd--;
            end
        end
    end

    // stream side: ready pattern and word checks
    int   stall_mode = 0;
    int   exp_chan = 0;
    int   words = 0;
    int   rdy_ctr = 0;
    logic pv = 1'b0, pr = 1'b0;
    logic [15:0] pdata = '0;
    logic [2:0]  pchan = '0;

    initial begin
        forever begin
            @(negedge clk);
            rdy_ctr++;
            m_ready = ((rdy_ctr % (stall_mode + 1)) == 0);
            #1;
            if (pv && !pr && rst_n) begin
                check(m_valid && m_data == pdata && m_chan == pchan, "R6",
                      "held word", int'(m_data), int'(pdata));
            end
            if (m_valid && m_ready) begin
                check(int'(m_chan) == exp_chan, "R5", "channel index", int'(m_chan), exp_chan);
                check(m_data == smp(mdl_frame, exp_chan), "R5", "sample word",
                      int'(m_data), int'(smp(mdl_frame, exp_chan)));
                check(m_last == (exp_chan == 5), "R5", "last flag", int'(m_last),
                      int'(exp_chan == 5));
                words++;
                exp_chan = (exp_chan + 1) % 6;
            end
            pv = m_valid; pr = m_ready; pdata = m_data; pchan = m_chan;
        end
    end

    // pin monitors
    int cyc = 0;
    int strb_n = 0, strb_bad = 0, exp_rd_addr = 0;
    int hold_n = 0, hold_bad = 0, hold_fall_cyc = 0;
    int tmo_n = 0, tmo_cyc = 0, ovr_n = 0;

    initial begin
        int   lowcnt = 0;
        int   holdw = 0;
        logic [2:0] saddr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!cnv_rd_n) begin
                if (lowcnt == 0) begin
                    saddr = cnv_addr;
                    if (int'(cnv_addr) != exp_rd_addr) strb_bad++;
                    exp_rd_addr = (exp_rd_addr + 1) % 6;
                end
                if (cnv_cs_n || cnv_addr != saddr) strb_bad++;
                lowcnt++;
            end else if (lowcnt > 0) begin
                if (lowcnt != READC) strb_bad++;
                strb_n++;
                lowcnt = 0;
            end
            if (cnv_hold) begin
                if (!cnv_cs_n) hold_bad++;
                holdw++;
            end else if (holdw > 0) begin
                if (holdw != HOLDC) hold_bad++;
                hold_n++;
                hold_fall_cyc = cyc;
                holdw = 0;
            end
            if (timeout) begin
                tmo_n++;
                tmo_cyc = cyc;
            end
            if (overrun) ovr_n++;
        end
    end

    task automatic pulse_trig();
        @(negedge clk);
        sync_trig = 1'b1;
        repeat (4) @(negedge clk);
        sync_trig = 1'b0;
    endtask

    task automatic wait_words(input int target);
        for (int i = 0; i < 4000 && words < target; i++) @(negedge clk);
    endtask

    task automatic run_frame(input int mode, input int dly, input string req);
        int w0, s0, h0;
        stall_mode = mode;
        eoc_dly = dly;
        exp_chan = 0;
        exp_rd_addr = 0;
        w0 = words; s0 = strb_n; h0 = hold_n;
        strb_bad = 0; hold_bad = 0;
        pulse_trig();
        wait_words(w0 + 6);
        repeat (4) @(negedge clk);
        check(words - w0 == 6, req, "words per frame", words - w0, 6);
        check(strb_n - s0 == 6, "R4", "read strobes per frame", strb_n - s0, 6);
        check(strb_bad == 0, "R4", "strobe width/address errors", strb_bad, 0);
        check(hold_n - h0 == 1, "R3", "hold pulses per trigger", hold_n - h0, 1);
        check(hold_bad == 0, "R3", "hold width errors", hold_bad, 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n, hi, per, w0, s0, h0, o0, dt;
        bit seen;
        // reset state and startup reset pulse, trigger held high throughout
        sync_trig = 1'b1;
        repeat (5) @(negedge clk);
        check(!cnv_rst_n && !m_valid && cnv_cs_n && !cnv_hold, "R2", "reset state",
              int'({cnv_rst_n, m_valid, cnv_cs_n, cnv_hold}), 2);
        rst_n = 1'b1;
        n = 0;
        while (!cnv_rst_n && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(n == RSTC, "R2", "converter reset width", n, RSTC);
        repeat (20) @(negedge clk);
        sync_trig = 1'b0;
        repeat (20) @(negedge clk);
        check(hold_n == 0 && ovr_n == 0 && words == 0, "R2", "trigger ignored in reset",
              hold_n + ovr_n + words, 0);

        // R1: converter clock period and duty
        while (cnv_clk) @(negedge clk);
        while (!cnv_clk) @(negedge clk);
        per = 0; hi = 0; seen = 0;
        while (!(seen && cnv_clk)) begin
            if (cnv_clk) hi++;
            else seen = 1;
            per++;
            @(negedge clk);
        end
        check(per == 2 * HALF, "R1", "converter clock period", per, 2 * HALF);
        check(hi == HALF, "R1", "converter clock high time", hi, HALF);

        // sweep of back-pressure patterns and converter delays
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 3; d++) begin
                run_frame(m, 2 + d * 9, "R5");
            end
        end
        // R9: end-of-conversion while a word is held by back-pressure
        run_frame(3, 1, "R9");
        run_frame(5, 1, "R9");

        // R7: trigger during a frame
        stall_mode = 3; eoc_dly = 11; exp_chan = 0; exp_rd_addr = 0;
        w0 = words; h0 = hold_n; o0 = ovr_n;
        pulse_trig();
        repeat (40) @(negedge clk);
        pulse_trig();
        wait_words(w0 + 6);
        repeat (200) @(negedge clk);
        check(ovr_n - o0 == 1, "R7", "overrun pulses", ovr_n - o0, 1);
        check(hold_n - h0 == 1, "R7", "holds with re-trigger", hold_n - h0, 1);
        check(words - w0 == 6, "R7", "words with re-trigger", words - w0, 6);

        // R8: no end-of-conversion for the first pair
        stall_mode = 0; skip_pair = 0; exp_chan = 0; exp_rd_addr = 0;
        w0 = words; s0 = strb_n; n = tmo_n;
        pulse_trig();
        for (int i = 0; i < 3000 && tmo_n == n; i++) @(negedge clk);
        dt = tmo_cyc - hold_fall_cyc;
        check(tmo_n - n == 1, "R8", "timeout pulses", tmo_n - n, 1);
        check(dt >= (TMO - 1) * 2 * HALF && dt <= (TMO + 1) * 2 * HALF, "R8",
              "timeout delay", dt, TMO * 2 * HALF);
        repeat (50) @(negedge clk);
        check(words == w0 && strb_n == s0, "R8", "no reads after timeout",
              words - w0 + strb_n - s0, 0);

        // R8: timeout on the second pair
        skip_pair = 1; w0 = words; n = tmo_n; exp_chan = 0; exp_rd_addr = 0;
        pulse_trig();
        for (int i = 0; i < 3000 && tmo_n == n; i++) @(negedge clk);
        repeat (50) @(negedge clk);
        check(tmo_n - n == 1, "R8", "timeout on second pair", tmo_n - n, 1);
        check(words - w0 == 2, "R8", "words before timeout", words - w0, 2);
        skip_pair = -1;
        run_frame(1, 4, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule